// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. Both bus lines arrive asynchronously and are sampled by a faster system clock through a short synchronizer chain. A small edge detector turns the sampled lines into four events:

- clock rising,
- clock falling,
- start,
- stop.

A byte-level controller walks a transaction on these events. It decodes the device-select byte, acknowledges or stays silent, and collects a word address and a data byte. It then writes that byte into an internal array, or it streams bytes out of the array in a read.

The data line is open-drain. The block never drives a high level: it only asserts `sda_oe`, which pulls the line low.

A parameter picks one of three densities: 512, 1024 or 2048 bytes. The density decides how many of the three strap inputs take part in the select match. The select bits that are not compared become the high bits of the memory address.

Top module: `tws_eeprom_slave`

## Requirements
- R1: After reset the block does not pull the data line low (`sda_oe` = 0) and ignores the bus until a start condition.
- R2: The select byte is received most significant bit first. If its upper nibble (bits 7..4) is not 4'b1010, the block gives no acknowledge.
- R3: Select-byte bits 3, 2 and 1 line up with straps A2, A1 and A0. DENSITY=0 compares bit 3 with A2 and bit 2 with A1. DENSITY=1 compares only bit 3 with A2. DENSITY=2 compares none of them. A0 is never compared. A mismatch on any compared bit returns the block to idle with no acknowledge.
- R4: On a select match the block pulls SDA low through the whole high phase of the 9th clock. It releases the line after that clock falls.
- R5: In a write, the block also acknowledges the 8-bit word address (18th clock) and the data byte (27th clock).
- R6: The received byte is written to the array only when a stop condition follows. The array address is {uncompared select bits (bit 1 up to bit DENSITY+1), word address}.
- R7: A start condition that arrives after the data byte but before a stop discards the pending write.
- R8: A select byte with bit 0 = 1 loads the uncompared select bits into the high address bits. The block then sends the addressed byte MSB first and increments the address after each byte. It sends another byte when the master acknowledges, and releases the line for good when the master does not.
- R9: A start or stop condition at any point, including in the middle of a byte, abandons the byte in progress. A following transaction is then decoded from its first bit.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 leaves it released |
| strap_a2 | input | 1 | Hard-wired select strap, compared with select bit 3 |
| strap_a1 | input | 1 | Hard-wired select strap, compared with select bit 2 |
| strap_a0 | input | 1 | Hard-wired select strap, never compared |

## Verification
All three densities run side by side on separate data lines. The bench sweeps every strap value against every select pattern, so a mask that compared the wrong bit would acknowledge a foreign device or stay silent for its own. Bytes are written with distinct select and word-address pairs and read back through random and sequential reads. A wrong high-address concatenation would alias two writes, and a missing increment would return the first byte twice. The bench also sends a repeated start before the stop, which a design committing on the data acknowledge would wrongly store. Finally it aborts bytes halfway, which a design that kept its bit counter would misframe.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADR,
    ST_ACK_WADR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_RD_MACK,
    ST_WAIT
  } tws_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // bit i of the mask covers select-byte bit i+1 / strap i
  function automatic logic [2:0] cmp_mask(input int free);
    logic [2:0] m;
    for (int i = 0; i < 3; i++) m[i] = (i >= free);
    return m;
  endfunction

endpackage

// File: rtl/tws_sync.sv
`timescale 1ns/1ps
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

  // R9: bus events never coincide, so abort handling has one cause per cycle
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));

endmodule

// File: rtl/tws_match.sv
`timescale 1ns/1ps
module tws_match
  import tws_pkg::*;
#(
  parameter int FREE = 1
) (
  input  logic [7:1]      dev_bits,
  input  logic [2:0]      straps,
  output logic            hit,
  output logic [FREE-1:0] page
);

  localparam logic [2:0] MASK = cmp_mask(FREE);

  assign hit  = (dev_bits[7:4] == DEV_TYPE) &&
                (((dev_bits[3:1] ^ straps) & MASK) == 3'b000);
  assign page = dev_bits[FREE:1];

endmodule

// File: rtl/tws_store.sv
`timescale 1ns/1ps
module tws_store #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/tws_ctrl.sv
`timescale 1ns/1ps
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int FREE = 1,
  parameter int AW   = 8 + FREE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_lvl,
  input  logic            sda_lvl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            hit,
  input  logic [FREE-1:0] page,
  input  logic [7:0]      rd_byte,
  output logic [7:1]      dev_bits,
  output logic            sda_oe,
  output logic            mem_we,
  output logic [AW-1:0]   ptr,
  output logic [7:0]      wr_byte
);

  tws_state_e    state_q, state_n;
  logic [2:0]    cnt_q, cnt_n;
  logic          full_q, full_n;
  logic [7:0]    sreg_q, sreg_n;
  logic          oe_q, oe_n;
  logic          rw_q, rw_n;
  logic          wpend_q, wpend_n;
  logic [7:0]    wbuf_q, wbuf_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          nack_q, nack_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    full_n  = full_q;
    sreg_n  = sreg_q;
    oe_n    = oe_q;
    rw_n    = rw_q;
    wpend_n = wpend_q;
    wbuf_n  = wbuf_q;
    ptr_n   = ptr_q;
    nack_n  = nack_q;
    mem_we  = 1'b0;
    if (start_evt) begin
      state_n = ST_DEV;
      cnt_n   = 3'd0;
      full_n  = 1'b0;
      oe_n    = 1'b0;
      wpend_n = 1'b0;
    end else if (stop_evt) begin
      mem_we  = wpend_q;
      state_n = ST_IDLE;
      cnt_n   = 3'd0;
      full_n  = 1'b0;
      oe_n    = 1'b0;
      wpend_n = 1'b0;
    end else if (scl_rise) begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          sreg_n = {sreg_q[6:0], sda_lvl};
          if (cnt_q == 3'd7) full_n = 1'b1;
          else               cnt_n  = cnt_q + 3'd1;
        end
        ST_RDAT: begin
          if (cnt_q == 3'd7) full_n = 1'b1;
          else               cnt_n  = cnt_q + 3'd1;
        end
        ST_RD_MACK: nack_n = sda_lvl;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_DEV: if (full_q) begin
          full_n = 1'b0;
          cnt_n  = 3'd0;
          if (hit) begin
            oe_n    = 1'b1;
            rw_n    = sreg_q[0];
            ptr_n[AW-1:8] = page;
            state_n = ST_ACK_DEV;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_WADR: if (full_q) begin
          full_n     = 1'b0;
          cnt_n      = 3'd0;
          ptr_n[7:0] = sreg_q;
          oe_n       = 1'b1;
          state_n    = ST_ACK_WADR;
        end
        ST_WDAT: if (full_q) begin
          full_n  = 1'b0;
          cnt_n   = 3'd0;
          wbuf_n  = sreg_q;
          wpend_n = 1'b1;
          oe_n    = 1'b1;
          state_n = ST_ACK_WDAT;
        end
        ST_ACK_DEV: begin
          if (rw_q) begin
            sreg_n  = rd_byte;
            oe_n    = ~rd_byte[7];
            cnt_n   = 3'd0;
            state_n = ST_RDAT;
          end else begin
            oe_n    = 1'b0;
            state_n = ST_WADR;
          end
        end
        ST_ACK_WADR: begin
          oe_n    = 1'b0;
          state_n = ST_WDAT;
        end
        ST_ACK_WDAT: begin
          oe_n    = 1'b0;
          state_n = ST_WAIT;
        end
        ST_RDAT: begin
          if (full_q) begin
            full_n  = 1'b0;
            oe_n    = 1'b0;
            ptr_n   = ptr_q + 1'b1;
            state_n = ST_RD_MACK;
          end else begin
            sreg_n = {sreg_q[6:0], 1'b0};
            oe_n   = ~sreg_q[6];
          end
        end
        ST_RD_MACK: begin
          if (!nack_q) begin
            sreg_n  = rd_byte;
            oe_n    = ~rd_byte[7];
            cnt_n   = 3'd0;
            state_n = ST_RDAT;
          end else begin
            state_n = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      full_q  <= 1'b0;
      sreg_q  <= 8'h00;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      wpend_q <= 1'b0;
      wbuf_q  <= 8'h00;
      ptr_q   <= '0;
      nack_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      full_q  <= full_n;
      sreg_q  <= sreg_n;
      oe_q    <= oe_n;
      rw_q    <= rw_n;
      wpend_q <= wpend_n;
      wbuf_q  <= wbuf_n;
      ptr_q   <= ptr_n;
      nack_q  <= nack_n;
    end
  end

  assign dev_bits = sreg_q[7:1];
  assign sda_oe   = oe_q;
  assign ptr      = ptr_q;
  assign wr_byte  = wbuf_q;

  // R10: drive changes happen only while the sampled clock is low
  a_r10_drive_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);

  // R2: a select byte with the wrong type nibble is never acknowledged
  a_r2_no_ack_bad_type: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state_q == ST_DEV && full_q && sreg_q[7:4] != DEV_TYPE) |=> !oe_q);

  // R4: every acknowledge state holds the line low while the clock is high
  a_r4_ack_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACK_DEV || state_q == ST_ACK_WADR || state_q == ST_ACK_WDAT)
      && scl_lvl) |-> oe_q);

  // R8: after a master NACK or a finished write the line stays released
  a_r8_released_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT || state_q == ST_IDLE || state_q == ST_RD_MACK) |-> !oe_q);

endmodule

// File: rtl/tws_eeprom_slave.sv
`timescale 1ns/1ps
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int DENSITY     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic strap_a2,
  input  logic strap_a1,
  input  logic strap_a0
);

  localparam int FREE = DENSITY + 1;
  localparam int AW   = 8 + FREE;

  logic [1:0] rst_sh;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic hit, mem_we;
  logic [FREE-1:0] page;
  logic [7:1]      dev_bits;
  logic [7:0]      rd_byte, wr_byte;
  logic [AW-1:0]   ptr;

  tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tws_match #(.FREE(FREE)) u_match (
    .dev_bits (dev_bits),
    .straps   ({strap_a2, strap_a1, strap_a0}),
    .hit      (hit),
    .page     (page)
  );

  tws_ctrl #(.FREE(FREE), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .hit       (hit),
    .page      (page),
    .rd_byte   (rd_byte),
    .dev_bits  (dev_bits),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .ptr       (ptr),
    .wr_byte   (wr_byte)
  );

  tws_store #(.AW(AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr),
    .wdata (wr_byte),
    .rdata (rd_byte)
  );

  // R6: the array is written only in a cycle that sees a stop condition
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (stop_evt && scl_lvl));

  // R1: the line is released while reset is held
  a_r1_reset_released: assert property (@(posedge clk)
    !rst_int_n |-> !sda_oe);

endmodule

// File: tb/sim_tws_eeprom_slave.sv
`timescale 1ns/1ps
module sim_tws_eeprom_slave;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       sda_m;
  logic [2:0] straps;
  logic [2:0] oe;
  logic [2:0] line;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  assign line = {3{sda_m}} & ~oe;

  tws_eeprom_slave #(.DENSITY(0)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line[0]), .sda_oe(oe[0]),
    .strap_a2(straps[2]), .strap_a1(straps[1]), .strap_a0(straps[0]));
  tws_eeprom_slave #(.DENSITY(1)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line[1]), .sda_oe(oe[1]),
    .strap_a2(straps[2]), .strap_a1(straps[1]), .strap_a0(straps[0]));
  tws_eeprom_slave #(.DENSITY(2)) u2 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line[2]), .sda_oe(oe[2]),
    .strap_a2(straps[2]), .strap_a1(straps[1]), .strap_a0(straps[0]));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int v, input logic [2:0] d, input logic [2:0] s);
    case (v)
      0:       return d[2:1] == s[2:1];
      1:       return d[2] == s[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] fdat(input logic [2:0] d, input logic [7:0] lo);
    return 8'((int'(lo) * 3 + int'(d) * 29 + 1) & 255);
  endfunction

  task automatic clk_bit(input logic b, output logic [2:0] s);
    logic [2:0] s1;
    tick(5);
    sda_m = b;
    tick(5);
    scl = 1'b1;
    tick(2);
    s1 = line;
    tick(5);
    s = line;
    check(s1 == s, "R10", "line moved while SCL high", int'(s), int'(s1));
    tick(3);
    scl = 1'b0;
  endtask

  task automatic do_start;
    tick(5); sda_m = 1'b1;
    tick(5); scl = 1'b1;
    tick(5); sda_m = 1'b0;
    tick(5); scl = 1'b0;
  endtask

  task automatic do_stop;
    tick(5); sda_m = 1'b0;
    tick(5); scl = 1'b1;
    tick(5); sda_m = 1'b1;
    tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [2:0] ack);
    logic [2:0] s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [2:0][7:0] r);
    logic [2:0] s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      for (int k = 0; k < 3; k++) r[k][i] = s[k];
    end
    clk_bit(mack, s);
  endtask

  function automatic logic [2:0] exp_vec(input logic [2:0] d, input logic [2:0] s);
    logic [2:0] e;
    for (int k = 0; k < 3; k++) e[k] = exp_hit(k, d, s);
    return e;
  endfunction

  task automatic wr(input logic [2:0] d, input logic [7:0] lo, input logic [7:0] dat);
    logic [2:0] ack, e;
    e = exp_vec(d, straps);
    do_start;
    send_byte({4'b1010, d, 1'b0}, ack);
    check(ack == e, "R4", "select ack in write", int'(ack), int'(e));
    send_byte(lo, ack);
    check(ack == e, "R5", "word address ack", int'(ack), int'(e));
    send_byte(dat, ack);
    check(ack == e, "R5", "data ack", int'(ack), int'(e));
    tick(6);
    check(line == 3'b111, "R4", "line released after ack", int'(line), 7);
    do_stop;
  endtask

  task automatic rd_check(input logic [2:0] d, input logic [7:0] lo,
                          input logic [7:0] exp, input string req);
    logic [2:0] ack, e;
    logic [2:0][7:0] r;
    e = exp_vec(d, straps);
    do_start;
    send_byte({4'b1010, d, 1'b0}, ack);
    send_byte(lo, ack);
    do_start;
    send_byte({4'b1010, d, 1'b1}, ack);
    check(ack == e, "R8", "select ack in read", int'(ack), int'(e));
    recv_byte(1'b1, r);
    for (int k = 0; k < 3; k++)
      if (e[k]) check(r[k] == exp, req, $sformatf("read byte dens%0d", k), int'(r[k]), int'(exp));
    do_stop;
  endtask

  task automatic run_all;
    logic [2:0] ack;
    logic [2:0] s;
    logic [2:0][7:0] r;
    rst_n  = 1'b0;
    scl    = 1'b1;
    sda_m  = 1'b1;
    straps = 3'b000;
    tick(5);
    check(oe == 3'b000, "R1", "drive during reset", int'(oe), 0);
    rst_n = 1'b1;
    tick(8);
    check(oe == 3'b000, "R1", "drive after reset", int'(oe), 0);

    // R3: every strap value against every select pattern
    for (int sv = 0; sv < 8; sv++) begin
      for (int dv = 0; dv < 8; dv++) begin
        straps = 3'(sv);
        do_start;
        send_byte({4'b1010, 3'(dv), 1'b0}, ack);
        for (int k = 0; k < 3; k++)
          check(ack[k] == exp_hit(k, 3'(dv), 3'(sv)), "R3",
                $sformatf("match dens%0d s=%0d d=%0d", k, sv, dv),
                int'(ack[k]), int'(exp_hit(k, 3'(dv), 3'(sv))));
        do_stop;
      end
    end

    // R2: every wrong type nibble
    straps = 3'b000;
    for (int nb = 0; nb < 16; nb++) begin
      if (nb != 10) begin
        do_start;
        send_byte({4'(nb), 4'b0000}, ack);
        check(ack == 3'b000, "R2", $sformatf("type nibble %0h", nb), int'(ack), 0);
        do_stop;
      end
    end

    // R6: writes with distinct select/word pairs, then read back
    for (int i = 0; i < 16; i++)
      wr(3'(i % 8), 8'((i * 37 + 5) % 256), fdat(3'(i % 8), 8'((i * 37 + 5) % 256)));
    wr(3'd0, 8'd200, fdat(3'd0, 8'd200));
    wr(3'd0, 8'd201, fdat(3'd0, 8'd201));
    for (int i = 0; i < 16; i++)
      rd_check(3'(i % 8), 8'((i * 37 + 5) % 256), fdat(3'(i % 8), 8'((i * 37 + 5) % 256)), "R6");

    // R8: sequential read with master ACK then NACK
    do_start;
    send_byte(8'b1010_0000, ack);
    send_byte(8'd200, ack);
    do_start;
    send_byte(8'b1010_0001, ack);
    check(ack == 3'b111, "R8", "read select ack", int'(ack), 7);
    recv_byte(1'b0, r);
    for (int k = 0; k < 3; k++)
      check(r[k] == fdat(3'd0, 8'd200), "R8", "first sequential byte", int'(r[k]), int'(fdat(3'd0, 8'd200)));
    recv_byte(1'b1, r);
    for (int k = 0; k < 3; k++)
      check(r[k] == fdat(3'd0, 8'd201), "R8", "incremented byte", int'(r[k]), int'(fdat(3'd0, 8'd201)));
    tick(6);
    check(line == 3'b111, "R8", "released after NACK", int'(line), 7);
    clk_bit(1'b1, s);
    check(s == 3'b111, "R8", "no drive after NACK", int'(s), 7);
    do_stop;

    // R7: repeated start before stop drops the write
    wr(3'd0, 8'd60, 8'h11);
    do_start;
    send_byte(8'b1010_0000, ack);
    send_byte(8'd60, ack);
    send_byte(8'h22, ack);
    check(ack == 3'b111, "R7", "data ack before abort", int'(ack), 7);
    do_start;
    do_stop;
    rd_check(3'd0, 8'd60, 8'h11, "R7");

    // R9: start in mid-byte, then stop in mid-byte
    do_start;
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    do_start;
    send_byte(8'b1010_0000, ack);
    check(ack == 3'b111, "R9", "ack after mid-byte start", int'(ack), 7);
    do_stop;
    do_start;
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    do_stop;
    do_start;
    send_byte(8'b1010_0000, ack);
    check(ack == 3'b111, "R9", "ack after mid-byte stop", int'(ack), 7);
    do_stop;
    check(oe == 3'b000, "R9", "idle after stop", int'(oe), 0);
  endtask

  initial begin
    fork
      run_all;
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule